// File: doc/BRIEF.md
# Transmit Frame Buffer Formatter

This block takes one outgoing Ethernet frame as a byte stream, with a start marker on the first byte and an end marker on the last. It holds the frame internally while it arrives. Once the end marker is seen, it copies the frame into a packet-buffer slot as a burst of 16-bit word writes through a pointer that advances on its own. Frame allocation, the MAC and the CRC are handled elsewhere.

The slot layout has a fixed shape. Offset 0 holds a zeroed status word and offset 2 holds a byte-count word. The payload starts at offset 4. The layout ends with a control word, which carries the final byte when the stored length is odd. These three extra words add 6 bytes of overhead. Frames below the minimum Ethernet length are zero-padded before they are stored. A frame that does not fit the slot is rejected with an error pulse and nothing is written. A done pulse marks the end of a successful burst.

Top module: `tx_frame_fmt`

## Requirements
- R1: The first word of every burst is written to offset 0 and carries the value 0x0000 (status).
- R2: The second word, at offset 2, equals the padded length plus 6.
- R3: A frame of fewer than MIN_LEN bytes (default 60) is stored as MIN_LEN bytes, and the added bytes are zero.
- R4: Payload byte 2k goes to bits [7:0] and byte 2k+1 to bits [15:8] of the word at offset 4+2k (little-endian).
- R5: When the padded length is even, the last word of the burst is a control word of value 0x0000.
- R6: When the padded length is odd, the control word is 0x2000 OR the final byte: the byte sits in bits [7:0] and bit 13 is set.
- R7: Writes occur in back-to-back cycles. The first write comes in the second cycle after the end-marker beat, at offset 0, and each later write is at the previous offset plus 2.
- R8: `done` is high for exactly one cycle, in the cycle right after the control word is written.
- R9: A frame longer than MAX_LEN bytes (default 2042) produces a one-cycle `err` pulse in the cycle after its end-marker beat, and causes no write and no `done`.
- R10: Input beats are ignored from the cycle after an accepted end marker until `done`. Beats without a start marker are ignored while no frame is open.
- R11: A start marker inside an open frame discards the bytes collected so far and begins a new frame.
- R12: During and right after reset, `wr_en`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is present |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| wr_en | output | 1 | Word write strobe |
| wr_addr | output | ADDR_W | Byte offset of the word within the slot |
| wr_data | output | 16 | Word to write |
| done | output | 1 | Burst finished, one-cycle pulse |
| err | output | 1 | Frame rejected as too long, one-cycle pulse |

## Verification
The assertions assume that the source sends nothing useful while a burst is being written. They also assume that MIN_LEN+6 and MAX_LEN+6 fit into 16 bits. The stimulus meets these assumptions. On some frames it also drives start- and end-marked noise beats during the whole burst window, and the content checks then show that the noise was dropped. The bench sweeps every frame length from 1 to two past MAX_LEN on a reduced MAX_LEN. This covers the padding edge, both control-word parities, the exact-fit frame and the rejected frames. Restarted frames and stray unmarked beats are mixed into the sweep.

// File: rtl/tx_fmt_pkg.sv
package tx_fmt_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned WORD_W       = 16;
  localparam int unsigned HDR_WORDS    = 2;   // status + count ahead of payload
  localparam int unsigned OVERHEAD_B   = 6;   // status + count + control bytes
  localparam int unsigned ODD_FLAG_BIT = 13;  // control-word flag for odd length

  typedef enum logic [0:0] {
    EM_IDLE = 1'b0,
    EM_RUN  = 1'b1
  } emit_state_e;
endpackage

// File: rtl/tx_fmt_capture.sv
module tx_fmt_capture
  import tx_fmt_pkg::*;
#(
  parameter int MAX_LEN = 2042,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int DEPTH   = (MAX_LEN + 1) / 2,
  parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [BYTE_W-1:0]  in_data,
  input  logic               busy,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [WORD_W-1:0]  rd_word,
  output logic [LEN_W-1:0]   frame_len,
  output logic               frame_ok,
  output logic               frame_err
);
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] cnt_q, cnt_d, base;
  logic             open_q, open_d, ovf_q, ovf_d;
  logic             ok_q, ok_d, err_q, err_d;
  logic             accept, start, cont, take, room, store, finish;
  logic             cnt_en, open_en;
  logic [IDX_W-1:0] wr_idx;

  // next-state
  always_comb begin
    accept  = in_valid & ~busy;
    start   = accept & in_sop;
    cont    = accept & ~in_sop & open_q;
    take    = start | cont;
    base    = start ? '0 : cnt_q;
    room    = (base != LIMIT);
    store   = take & room;
    finish  = take & in_eop;
    cnt_en  = store | start;
    cnt_d   = store ? base + LEN_W'(1) : base;
    open_en = take;
    open_d  = ~in_eop;
    if (start)              ovf_d = 1'b0;
    else if (cont && !room) ovf_d = 1'b1;
    else                    ovf_d = ovf_q;
    ok_d    = finish & ~ovf_d;
    err_d   = finish & ovf_d;
    wr_idx  = IDX_W'(base >> 1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      ovf_q  <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (open_en) open_q <= open_d;
      if (take)    ovf_q  <= ovf_d;
      ok_q  <= ok_d;
      err_q <= err_d;
    end
  end

  // two byte lanes of frame storage
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic              lane_hit;
    assign lane_hit = store & (base[0] == 1'(g));
    always_ff @(posedge clk) begin
      if (lane_hit) mem[wr_idx] <= in_data;
    end
    assign rd_word[g*BYTE_W +: BYTE_W] = mem[rd_idx];
  end

  assign frame_len = cnt_q;
  assign frame_ok  = ok_q;
  assign frame_err = err_q;
endmodule

// File: rtl/tx_fmt_emit.sv
module tx_fmt_emit
  import tx_fmt_pkg::*;
#(
  parameter int MAX_LEN = 2042,
  parameter int MIN_LEN = 60,
  parameter int ADDR_W  = 11,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int DEPTH   = (MAX_LEN + 1) / 2,
  parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   frame_len,
  output logic [IDX_W-1:0]   rd_idx,
  input  logic [WORD_W-1:0]  rd_word,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic               done,
  output logic               busy
);
  emit_state_e       st_q, st_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en, done_d, done_q;
  logic [15:0]       raw_len, pad_len, half, last_idx, idx, k, ctrl_idx;
  logic              is_status, is_count, is_ctrl, lo_ok, hi_ok;
  logic [BYTE_W-1:0] lo_b, hi_b;

  // word selection
  always_comb begin
    raw_len   = 16'(frame_len);
    pad_len   = (raw_len < 16'(MIN_LEN)) ? 16'(MIN_LEN) : raw_len;
    half      = pad_len >> 1;
    last_idx  = half + 16'(HDR_WORDS);
    idx       = 16'(ptr_q >> 1);
    k         = idx - 16'(HDR_WORDS);
    is_status = (idx == 16'd0);
    is_count  = (idx == 16'd1);
    is_ctrl   = (idx == last_idx);
    lo_ok     = ((k << 1) < raw_len) & ~is_status & ~is_count & ~is_ctrl;
    hi_ok     = (((k << 1) + 16'd1) < raw_len) & lo_ok;
    ctrl_idx  = (pad_len - 16'd1) >> 1;
    if (is_ctrl)    rd_idx = IDX_W'(ctrl_idx);
    else if (lo_ok) rd_idx = IDX_W'(k);
    else            rd_idx = '0;
    lo_b = lo_ok ? rd_word[BYTE_W-1:0]        : '0;
    hi_b = hi_ok ? rd_word[WORD_W-1:BYTE_W]   : '0;
    if (is_status)    wr_data = '0;
    else if (is_count) wr_data = pad_len + 16'(OVERHEAD_B);
    else if (is_ctrl)  wr_data = pad_len[0]
                                 ? ((16'd1 << ODD_FLAG_BIT) | 16'(rd_word[BYTE_W-1:0]))
                                 : 16'd0;
    else               wr_data = {hi_b, lo_b};
  end

  // next-state
  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    done_d = 1'b0;
    unique case (st_q)
      EM_IDLE: if (start) begin
        st_d   = EM_RUN;
        ptr_d  = '0;
        ptr_en = 1'b1;
      end
      EM_RUN: if (is_ctrl) begin
        st_d   = EM_IDLE;
        done_d = 1'b1;
      end else begin
        ptr_d  = ptr_q + ADDR_W'(2);
        ptr_en = 1'b1;
      end
      default: st_d = EM_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EM_IDLE;
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      if (ptr_en) ptr_q <= ptr_d;
      done_q <= done_d;
    end
  end

  assign wr_en   = (st_q == EM_RUN);
  assign wr_addr = ptr_q;
  assign done    = done_q;
  assign busy    = (st_q == EM_RUN);
endmodule

// File: rtl/tx_frame_fmt.sv
module tx_frame_fmt
  import tx_fmt_pkg::*;
#(
  parameter  int MAX_LEN = 2042,
  parameter  int MIN_LEN = 60,
  localparam int BIG     = (MAX_LEN > MIN_LEN) ? MAX_LEN : MIN_LEN,
  localparam int ADDR_W  = $clog2(BIG + 6)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              done,
  output logic              err
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int DEPTH = (MAX_LEN + 1) / 2;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  logic rst_core_n;
  assign rst_core_n = rst_sync_q[1];

  logic             cap_ok, cap_err, em_busy, hold;
  logic [LEN_W-1:0] flen;
  logic [IDX_W-1:0] rd_idx;
  logic [15:0]      rd_word;

  assign hold = cap_ok | em_busy;

  tx_fmt_capture #(.MAX_LEN(MAX_LEN)) u_cap (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_data   (in_data),
    .busy      (hold),
    .rd_idx    (rd_idx),
    .rd_word   (rd_word),
    .frame_len (flen),
    .frame_ok  (cap_ok),
    .frame_err (cap_err)
  );

  tx_fmt_emit #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN), .ADDR_W(ADDR_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (cap_ok),
    .frame_len (flen),
    .rd_idx    (rd_idx),
    .rd_word   (rd_word),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done      (done),
    .busy      (em_busy)
  );

  assign err = cap_err;
endmodule

// File: rtl/tx_frame_fmt_chk.sv
module tx_frame_fmt_chk #(
  parameter int MIN_LEN = 60,
  parameter int ADDR_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic              done,
  input logic              err
);
  p_status_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |-> (wr_data == 16'd0));

  p_count_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(2)) |-> (wr_data >= 16'(MIN_LEN + 6)));

  p_ptr_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> (wr_addr == '0));

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + ADDR_W'(2))));

  p_done_after_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && !wr_en));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_en && !done));

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

bind tx_frame_fmt tx_frame_fmt_chk #(.MIN_LEN(MIN_LEN), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .done    (done),
  .err     (err)
);

// File: tb/sim_tx_frame_fmt.sv
`timescale 1ns/1ps
module sim_tx_frame_fmt;
  localparam int MAXL = 128;
  localparam int MINL = 60;
  localparam int BIG  = (MAXL > MINL) ? MAXL : MINL;
  localparam int AW   = $clog2(BIG + 6);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_sop, in_eop;
  logic [7:0]    in_data;
  logic          wr_en, done, err;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  tx_frame_fmt #(.MAX_LEN(MAXL), .MIN_LEN(MINL)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .err(err)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected below 200000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int i, input int seed);
    return 8'(i * 29 + seed * 7 + 3);
  endfunction

  function automatic logic [15:0] exp_word(input int j, input int len, input int seed);
    int p, half, k;
    logic [7:0] lo, hi;
    p = (len < MINL) ? MINL : len;
    half = p / 2;
    if (j == 0) return 16'h0000;
    if (j == 1) return 16'(p + 6);
    if (j < 2 + half) begin
      k  = j - 2;
      lo = (2 * k < len)     ? bval(2 * k, seed)     : 8'h00;
      hi = (2 * k + 1 < len) ? bval(2 * k + 1, seed) : 8'h00;
      return {hi, lo};
    end
    if (p % 2 == 1) return 16'h2000 | 16'(bval(p - 1, seed));
    return 16'h0000;
  endfunction

  function automatic logic [31:0] pack(input logic we, input logic dn,
                                       input logic [AW-1:0] a, input logic [15:0] d);
    return (32'(we) << 31) | (32'(dn) << 30) | (32'(a) << 16) | 32'(d);
  endfunction

  task automatic idle_in();
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h00;
  endtask

  task automatic run_frame(input int len, input int seed, input bit noise, input int prefix);
    int p, n, half;
    bit exp_err;
    string tag;
    exp_err = (len > MAXL);
    p = (len < MINL) ? MINL : len;
    half = p / 2;
    n = 3 + half;
    for (int i = 0; i < prefix; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = 1'b0; in_data = 8'hC3 ^ 8'(i);
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == len - 1); in_data = bval(i, seed);
    end
    @(negedge clk);
    if (noise && !exp_err) begin
      in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'h5A;
    end else idle_in();
    chk(err == exp_err, "R9", "err one cycle after end marker", 32'(err), 32'(exp_err));
    chk(wr_en == 1'b0, "R7", "no write in first cycle after end marker", 32'(wr_en), 32'd0);
    if (exp_err) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        chk(!wr_en && !done && !err, "R9", "rejected frame stays silent",
            pack(wr_en, done, '0, 16'(err)), 32'd0);
      end
      return;
    end
    for (int c = 2; c <= n + 1; c++) begin
      int j;
      j = c - 2;
      @(negedge clk);
      if (noise) begin
        in_valid = 1'b1; in_sop = 1'b1; in_eop = c[0]; in_data = 8'(c * 3);
      end else idle_in();
      if (j == 0) tag = "R1";
      else if (j == 1) tag = (prefix > 0) ? "R11" : "R2";
      else if (j < 2 + half) tag = (2 * (j - 2) >= len) ? "R3" : "R4";
      else tag = (p % 2 == 1) ? "R6" : "R5";
      chk(pack(wr_en, done, wr_addr, wr_data) == pack(1'b1, 1'b0, AW'(2 * j), exp_word(j, len, seed)),
          tag, $sformatf("len %0d word %0d", len, j),
          pack(wr_en, done, wr_addr, wr_data), pack(1'b1, 1'b0, AW'(2 * j), exp_word(j, len, seed)));
    end
    @(negedge clk);
    idle_in();
    chk(done && !wr_en, "R8", "done after control word",
        pack(wr_en, done, '0, '0), pack(1'b0, 1'b1, '0, '0));
    @(negedge clk);
    chk(!done, "R8", "done lasts one cycle", 32'(done), 32'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!wr_en && !done && !err, "R10", "beats during burst ignored",
          pack(wr_en, done, '0, 16'(err)), 32'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    idle_in();
    repeat (3) @(negedge clk);
    chk(!wr_en && !done && !err, "R12", "outputs quiet in reset",
        pack(wr_en, done, '0, 16'(err)), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wr_en && !done && !err, "R12", "outputs quiet after reset",
        pack(wr_en, done, '0, 16'(err)), 32'd0);

    // stray beats with no start marker while no frame is open
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_eop = i[0]; in_data = 8'(i + 1);
      chk(!wr_en && !done && !err, "R10", "unmarked beats ignored",
          pack(wr_en, done, '0, 16'(err)), 32'd0);
    end
    @(negedge clk);
    idle_in();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!wr_en && !done && !err, "R10", "unmarked beats left no frame",
          pack(wr_en, done, '0, 16'(err)), 32'd0);
    end

    // sweep every length through the rejection boundary
    for (int len = 1; len <= MAXL + 2; len++) begin
      run_frame(len, len, (len % 3 == 0), (len % 5 == 0) ? 3 : 0);
    end

    summary();
    $finish;
  end
endmodule